// File: doc/BRIEF.md
# Sixteen-Line Asynchronous Receive Multiplexer

This block receives characters on sixteen asynchronous serial inputs at once. Every line uses the same character length and the same bit rate, both set by shared inputs, and all lines run from one shared oversampling tick generator. Each line has its own receiver. The receiver finds the start bit, checks that the start bit is still valid at mid-bit, and shifts in the data bits least significant first. It can also take a parity bit. It then samples the stop bit.

Each finished character becomes one 16-bit word. The word holds the right-justified character, the number of the line it came from, a stop-bit-valid flag and a parity-error flag. A one-entry holding register on each line keeps the word until a round-robin arbiter grants it the single write port of a 64-word circular buffer. The CPU side sees the oldest word directly on `rd_data` and pops it with `rd_en`. If a word arrives while the buffer is full, the word is dropped and a sticky overflow flag is raised. Software clears that flag with `ovf_clr`.

Top module: `async_rx_mux`

## Requirements
- R1: After reset, `buf_empty` is 1, and `buf_full` and `overflow` are 0.
- R2: Data bits are taken least significant first and stored right-justified in bits [7:0] of the word, with the first received bit in bit 0.
- R3: Bits [11:8] of a word hold the number (0 to 15) of the line that received the character. Bits [15:14] are always 0.
- R4: Bit 12 of a word is 1 when the stop bit was sampled high (mark) at its mid-point and 0 otherwise. A line that framed badly still accepts its next character.
- R5: With `par_en`=1, one parity bit follows the data. Bit 13 is 1 when the data bits plus the parity bit hold an odd count of ones (`par_odd`=0) or an even count (`par_odd`=1). With `par_en`=0, no parity bit is expected and bit 13 is 0.
- R6: `char_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits above the selected length read as 0.
- R7: A low level on a line that is gone before mid-bit of the start bit (8 oversampling ticks) produces no word.
- R8: When several lines finish in the same cycle, each character is written exactly once, one per cycle, granted round-robin. Characters from any one line keep their order.
- R9: The buffer holds 64 words. A word that arrives while the buffer is full is dropped and `overflow` is set. `buf_full` is 1 while 64 words are stored.
- R10: `overflow` stays 1 until `ovf_clr` is pulsed. A new drop in the same cycle as the clear wins.
- R11: `rd_data` shows the oldest word while `buf_empty` is 0, and `rd_en` pops it. `rd_en` while empty has no effect.
- R12: One oversampling tick is produced every `baud_div` clock cycles (one per cycle for 0 or 1), and each bit lasts 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 16 | Serial inputs, idle high, bit n is line n |
| baud_div | input | 16 | Clock cycles per oversampling tick |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Expect a parity bit after the data |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_en | input | 1 | Pop the oldest word |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| rd_data | output | 16 | Oldest stored word |
| buf_empty | output | 1 | No word stored |
| buf_full | output | 1 | 64 words stored |
| overflow | output | 1 | Sticky: a word was dropped |

## Verification
The bench first sends single characters on chosen lines. These show that bit order, right-justification and the line-number field are correct without any contention. All sixteen lines then finish in the same cycle, which shows that arbitration loses nothing and keeps the per-line order. Short-length, parity-good, parity-bad, broken-stop and glitch frames each change one status field or one acceptance rule on its own. Five full rounds sent with no reads push the buffer past capacity, which tells the stored words apart from the dropped ones and shows that the overflow flag is sticky and can be cleared.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    localparam int unsigned LINES  = 16;
    localparam int unsigned LINE_W = $clog2(LINES);
    localparam int unsigned OSR    = 16;
    localparam int unsigned OS_W   = $clog2(OSR);

    typedef struct packed {
        logic [1:0]        rsvd;
        logic              par_err;
        logic              stop_ok;
        logic [LINE_W-1:0] line;
        logic [7:0]        data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [7:0] char_mask(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction

endpackage

// File: rtl/rxm_baud_gen.sv
module rxm_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W:0]   nxt;

    assign nxt  = {1'b0, cnt} + 1'b1;
    assign tick = (nxt >= {1'b0, div});

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= nxt[DIV_W-1:0];
    end

    // R12
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div > 1 && $past(div) > 1) |=> !tick);

endmodule

// File: rtl/rxm_line_rx.sv
module rxm_line_rx
    import rxm_pkg::*;
#(
    parameter logic [LINE_W-1:0] LINE_ID = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_raw,
    input  logic [1:0] len_code,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       done,
    output rx_entry_t  entry
);
    localparam logic [OS_W-1:0] OS_MID  = OS_W'(OSR / 2 - 1);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OSR - 1);

    logic [1:0]      sync;
    logic            rx_s;
    rx_state_t       st;
    logic [OS_W-1:0] os;
    logic [3:0]      nb;
    logic [7:0]      sh;
    logic            pbit;
    logic [7:0]      rj;
    logic            perr;

    assign rx_s = sync[1];
    assign rj   = sh >> (2'd3 - len_code);
    assign perr = par_en & ((^rj) ^ pbit ^ par_odd);

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rx_raw};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            os    <= '0;
            nb    <= '0;
            sh    <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            entry <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: begin
                        if (!rx_s) begin
                            st <= ST_START;
                            os <= '0;
                        end
                    end
                    ST_START: begin
                        if (os == OS_MID) begin
                            os <= '0;
                            nb <= '0;
                            st <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            os <= os + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (os == OS_LAST) begin
                            os <= '0;
                            sh <= {rx_s, sh[7:1]};
                            nb <= nb + 4'd1;
                            if (nb == char_bits(len_code) - 4'd1)
                                st <= par_en ? ST_PAR : ST_STOP;
                        end else begin
                            os <= os + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (os == OS_LAST) begin
                            os   <= '0;
                            pbit <= rx_s;
                            st   <= ST_STOP;
                        end else begin
                            os <= os + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (os == OS_LAST) begin
                            os    <= '0;
                            st    <= ST_IDLE;
                            done  <= 1'b1;
                            entry <= '{rsvd: 2'b00, par_err: perr, stop_ok: rx_s,
                                       line: LINE_ID, data: rj};
                        end else begin
                            os <= os + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R6
    len_mask_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((entry.data & ~char_mask(len_code)) == 8'h00));

    // R7
    glitch_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && st == ST_START && os == OS_MID && rx_s) |=> (st == ST_IDLE && !done));

    // R3
    line_field_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (entry.line == LINE_ID && entry.rsvd == 2'b00));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/rxm_rr_arb.sv
module rxm_rr_arb #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr;
    logic          found;

    always_comb begin
        gnt     = '0;
        gnt_idx = ptr;
        found   = 1'b0;
        for (int k = 0; k < N; k++) begin : scan
            logic [IW-1:0] idx;
            idx = IW'((int'(ptr) + k) % N);
            if (!found && req[idx]) begin
                found      = 1'b1;
                gnt[idx]   = 1'b1;
                gnt_idx    = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (|req)
            ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end

    // R8
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R8
    gnt_in_req_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    // R8
    gnt_live_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt));

endmodule

// File: rtl/rxm_ring_buf.sv
module rxm_ring_buf #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic         ovf_clr,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    output logic         overflow
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW:0]   cnt;
    logic          do_wr;
    logic          do_rd;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 overflow <= 1'b0;
        else if (wr_en && full)  overflow <= 1'b1;
        else if (ovf_clr)        overflow <= 1'b0;
    end

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= (AW+1)'(DEPTH));

    // R9
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> overflow);

    // R10
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !(wr_en && full)) |=> !overflow);

    // R11
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> $stable(rp));

endmodule

// File: rtl/async_rx_mux.sv
module async_rx_mux
    import rxm_pkg::*;
#(
    parameter int NUM_LINES = LINES,
    parameter int DEPTH     = 64,
    parameter int DIV_W     = 16,
    localparam int IW       = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] rx_line,
    input  logic [DIV_W-1:0]     baud_div,
    input  logic [1:0]           char_len,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rd_en,
    input  logic                 ovf_clr,
    output logic [15:0]          rd_data,
    output logic                 buf_empty,
    output logic                 buf_full,
    output logic                 overflow
);
    logic                 tick;
    logic [NUM_LINES-1:0] done;
    logic [NUM_LINES-1:0] hold_vld;
    logic [NUM_LINES-1:0] gnt;
    logic [IW-1:0]        gnt_idx;
    rx_entry_t            ent      [NUM_LINES];
    rx_entry_t            hold_ent [NUM_LINES];
    rx_entry_t            wr_ent;

    rxm_baud_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .div  (baud_div),
        .tick (tick)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic      vld;
        rx_entry_t hold;

        rxm_line_rx #(.LINE_ID(LINE_W'(g))) u_rx (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .rx_raw   (rx_line[g]),
            .len_code (char_len),
            .par_en   (par_en),
            .par_odd  (par_odd),
            .done     (done[g]),
            .entry    (ent[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                vld  <= 1'b0;
                hold <= '0;
            end else if (done[g]) begin
                vld  <= 1'b1;
                hold <= ent[g];
            end else if (gnt[g]) begin
                vld  <= 1'b0;
            end
        end

        assign hold_vld[g] = vld;
        assign hold_ent[g] = hold;

        // R8
        no_lost_char_chk: assert property (@(posedge clk) disable iff (rst)
            !(done[g] && vld && !gnt[g]));
    end

    rxm_rr_arb #(.N(NUM_LINES)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (hold_vld),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    assign wr_ent = hold_ent[gnt_idx];

    rxm_ring_buf #(.DEPTH(DEPTH), .W(16)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (|hold_vld),
        .wr_data  (wr_ent),
        .rd_en    (rd_en),
        .ovf_clr  (ovf_clr),
        .rd_data  (rd_data),
        .empty    (buf_empty),
        .full     (buf_full),
        .overflow (overflow)
    );

    // R9
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(buf_full && buf_empty));

endmodule

// File: tb/async_rx_mux_tb.sv
`timescale 1ns/1ps
module async_rx_mux_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rx_line = '1;
    logic [15:0] baud_div = 16'd4;
    logic [1:0]  char_len = 2'd3;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        rd_en = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [15:0] rd_data;
    logic        buf_empty;
    logic        buf_full;
    logic        overflow;

    int n_tests = 0;
    int n_fail  = 0;
    int model_cnt = 0;
    logic [15:0] expq [16][$];

    always #2.5 clk = ~clk;

    async_rx_mux u_dut (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .baud_div  (baud_div),
        .char_len  (char_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .rd_en     (rd_en),
        .ovf_clr   (ovf_clr),
        .rd_data   (rd_data),
        .buf_empty (buf_empty),
        .buf_full  (buf_full),
        .overflow  (overflow)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int bit_clks();
        return 16 * ((baud_div < 2) ? 1 : int'(baud_div));
    endfunction

    // reference: word the requirements call for
    task automatic want(input int ln, input logic [7:0] d, input bit pbit, input bit stop_ok);
        int nb;
        logic [7:0] data;
        bit perr;
        nb   = int'(char_len) + 5;
        data = d & 8'((1 << nb) - 1);
        perr = par_en && ((^data) ^ pbit ^ par_odd);
        if (model_cnt < 64) begin
            expq[ln].push_back({2'b00, perr, stop_ok, 4'(ln), data});
            model_cnt++;
        end
    endtask

    task automatic send(input int ln, input logic [7:0] d, input bit pbit, input bit stop_ok);
        int bp;
        int nb;
        bp = bit_clks();
        nb = int'(char_len) + 5;
        @(negedge clk);
        rx_line[ln] = 1'b0;
        repeat (bp) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            rx_line[ln] = d[b];
            repeat (bp) @(negedge clk);
        end
        if (par_en) begin
            rx_line[ln] = pbit;
            repeat (bp) @(negedge clk);
        end
        if (stop_ok) begin
            rx_line[ln] = 1'b1;
            repeat (bp) @(negedge clk);
        end else begin
            rx_line[ln] = 1'b0;
            repeat (bp * 10 / 16) @(negedge clk);
            rx_line[ln] = 1'b1;
            repeat (bp) @(negedge clk);
        end
        repeat (bp) @(negedge clk);
    endtask

    task automatic send_checked(input int ln, input logic [7:0] d, input bit pbit, input bit stop_ok);
        want(ln, d, pbit, stop_ok);
        send(ln, d, pbit, stop_ok);
    endtask

    task automatic round(input int seed);
        for (int i = 0; i < 16; i++) want(i, 8'(seed + i * 7), 1'b0, 1'b1);
        for (int i = 0; i < 16; i++) begin
            automatic int k = i;
            fork
                send(k, 8'(seed + k * 7), 1'b0, 1'b1);
            join_none
        end
        wait fork;
        repeat (40) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        logic [15:0] e;
        logic [15:0] exp;
        int ln;
        int guard;
        int left;
        guard = 0;
        repeat (40) @(negedge clk);
        while (!buf_empty && guard < 100) begin
            e  = rd_data;
            ln = int'(e[11:8]);
            if (expq[ln].size() == 0) begin
                chk(1'b0, tag, 32'(e), 32'hFFFF_FFFF);
            end else begin
                exp = expq[ln].pop_front();
                chk(e == exp, tag, 32'(e), 32'(exp));
            end
            model_cnt--;
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            guard++;
        end
        left = 0;
        for (int i = 0; i < 16; i++) left += expq[i].size();
        chk(left == 0 && buf_empty, tag, 32'(left), 32'd0);
        model_cnt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(buf_empty == 1'b1, "R1 empty", 32'(buf_empty), 32'd1);
        chk(buf_full == 1'b0, "R1 full", 32'(buf_full), 32'd0);
        chk(overflow == 1'b0, "R1 overflow", 32'(overflow), 32'd0);

        // R2 and R3: single characters, no contention
        send_checked(3, 8'hA5, 1'b0, 1'b1);
        drain("R2/R3 line3");
        send_checked(14, 8'h01, 1'b0, 1'b1);
        drain("R2/R3 line14");

        // R8: all lines finish together
        round(8'h30);
        drain("R8 simultaneous");

        // R6: five- and six-bit characters
        char_len = 2'd0;
        send_checked(5, 8'hFF, 1'b0, 1'b1);
        send_checked(9, 8'h0A, 1'b0, 1'b1);
        drain("R6 len5");
        char_len = 2'd1;
        send_checked(11, 8'hE9, 1'b0, 1'b1);
        drain("R6 len6");
        char_len = 2'd3;

        // R5: parity good and bad, even and odd
        par_en = 1'b1;
        par_odd = 1'b0;
        send_checked(1, 8'h03, 1'b0, 1'b1);
        send_checked(2, 8'h07, 1'b0, 1'b1);
        drain("R5 even");
        par_odd = 1'b1;
        send_checked(4, 8'h07, 1'b0, 1'b1);
        send_checked(4, 8'h07, 1'b1, 1'b1);
        drain("R5 odd");
        par_en = 1'b0;

        // R4: broken stop then a normal character on the same line
        send_checked(6, 8'h55, 1'b0, 1'b0);
        send_checked(6, 8'h3C, 1'b0, 1'b1);
        drain("R4 stop flag");

        // R7: short low pulse gives nothing
        @(negedge clk);
        rx_line[7] = 1'b0;
        repeat (3 * int'(baud_div)) @(negedge clk);
        rx_line[7] = 1'b1;
        repeat (3 * bit_clks()) @(negedge clk);
        chk(buf_empty == 1'b1, "R7 glitch", 32'(buf_empty), 32'd1);
        send_checked(7, 8'hC3, 1'b0, 1'b1);
        drain("R7 after glitch");

        // R11: pop while empty has no effect
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(buf_empty == 1'b1, "R11 empty pop", 32'(buf_empty), 32'd1);
        send_checked(0, 8'h11, 1'b0, 1'b1);
        send_checked(0, 8'h22, 1'b0, 1'b1);
        drain("R11 order");

        // R12: different divider
        baud_div = 16'd2;
        send_checked(0, 8'h96, 1'b0, 1'b1);
        drain("R12 div2");
        baud_div = 16'd4;

        // R9 and R10: overflow
        for (int r = 0; r < 5; r++) round(8'h40 + r * 3);
        chk(buf_full == 1'b1, "R9 full", 32'(buf_full), 32'd1);
        chk(overflow == 1'b1, "R9 overflow", 32'(overflow), 32'd1);
        drain("R9 stored words");
        chk(overflow == 1'b1, "R10 sticky", 32'(overflow), 32'd1);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(overflow == 1'b0, "R10 clear", 32'(overflow), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule